// File: doc/BRIEF.md
# Reloading Square-Wave Timer

This block is a 16-bit up-counter that restarts from a programmable reload value each time it passes its all-ones state. Every such wrap inverts an internal toggle flop. When output is enabled, that flop is driven onto a pin, so the pin carries a square wave. Each half-period lasts (65536 − reload) count ticks. A tick occurs on every second system clock in normal mode, or on every system clock when the fast-rate bit is set.

A separate input pin is watched for falling edges. When edge capture is enabled, a falling edge sets a sticky event flag, and that flag drives the interrupt request line. The square wave keeps running throughout.

Software reaches the block through a byte-wide write strobe and a combinational read port. Address 0 holds the control byte. Addresses 1 and 2 hold the count bytes (low, high). Addresses 3 and 4 hold the reload bytes (low, high).

Top module: `sqwave_timer`

## Requirements
- R1: After reset, every register reads 0 and both clkOut and irq are low.
- R2: Control byte at address 0 has these fields: bit0 = run, bit1 = output enable, bit2 = edge-capture enable, bit3 = fast rate, bit7 = event flag; bits 6:4 read 0. Count low/high are at addresses 1/2 and reload low/high at 3/4. All of these read back what was last written (or counted), and any other address reads 0.
- R3: While run is 0 the count holds its value.
- R4: While run is 1, the count advances by one on every clock when fast rate is set, and on every second clock otherwise.
- R5: A tick that finds the count at 0xFFFF loads the reload value and inverts the toggle flop. The clkOut half-period is therefore (65536 − reload) ticks: (65536 − reload) clocks in fast rate and twice that otherwise.
- R6: clkOut follows the toggle flop only while output enable is 1 and is held low otherwise.
- R7: A write to a count byte lands exactly as written, even while the counter runs; the increment is dropped in that cycle.
- R8: With edge-capture enable at 1, a falling edge on extPin sets the event flag within four clocks. Rising edges, and any edge while the enable is 0, leave the flag unchanged.
- R9: irq mirrors the event flag. The flag stays set until a control write puts 0 in bit7; a control write with 1 in bit7 neither sets nor clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System (oscillator) clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Byte write strobe |
| addr | input | 3 | Register address |
| wrData | input | 8 | Write data |
| rdData | output | 8 | Combinational read data for addr |
| extPin | input | 1 | External trigger pin, falling edge active |
| clkOut | output | 1 | Square-wave output |
| irq | output | 1 | Event-flag interrupt request |

## Verification
The square-wave period is measured at the pin over a sweep of reload values: the five values closest to the top, plus one far from it, each in fast and normal rate. A reload of 0xFFFF, where the wave flips on every tick, tells a wrap-to-reload design apart from one that wraps to zero. The pairs of rates show whether the prescaler really halves the tick rate. Direct count readbacks after a known number of clocks, with run on and off, separate the rate from the gating. Mid-run byte writes show whether the write beats the increment. Falling, rising and disabled edges on the trigger pin, together with set-preserving and clearing control writes, pin down the sticky flag.

// File: rtl/sqt_pkg.sv
package sqt_pkg;
  localparam int unsigned BYTES  = 2;
  localparam int unsigned CNT_W  = 8 * BYTES;
  localparam int unsigned ADDR_W = 3;

  localparam logic [ADDR_W-1:0] A_CTRL = '0;

  localparam int unsigned B_RUN  = 0;
  localparam int unsigned B_OE   = 1;
  localparam int unsigned B_EXEN = 2;
  localparam int unsigned B_FAST = 3;
  localparam int unsigned B_FLAG = 7;

  typedef struct packed {
    logic             tick;
    logic             run;
    logic [BYTES-1:0] wrCnt;
    logic [BYTES-1:0] wrRld;
    logic [7:0]       wrByte;
  } dpStrb_t;

  function automatic logic [ADDR_W-1:0] cntAddr(input int unsigned lane);
    return ADDR_W'(1 + lane);
  endfunction

  function automatic logic [ADDR_W-1:0] rldAddr(input int unsigned lane);
    return ADDR_W'(1 + BYTES + lane);
  endfunction
endpackage

// File: rtl/sqt_ctrl.sv
module sqt_ctrl
  import sqt_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wrData,
  input  logic              extPin,
  input  logic [CNT_W-1:0]  countVal,
  input  logic [CNT_W-1:0]  reloadVal,
  output dpStrb_t           strb,
  output logic [7:0]        rdData,
  output logic              cfgOutEn,
  output logic              cfgExtEn,
  output logic              extFlag
);
  localparam int unsigned LAST = SYNC_STAGES - 1;

  logic cfgRun, cfgFast, divPhase;
  logic ctrlWr, flagClr, extPrev, extFall;
  logic [SYNC_STAGES-1:0] syncQ;

  assign ctrlWr  = wrEn && (addr == A_CTRL);
  assign flagClr = ctrlWr && !wrData[B_FLAG];

  // configuration bits
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfgRun   <= 1'b0;
      cfgOutEn <= 1'b0;
      cfgExtEn <= 1'b0;
      cfgFast  <= 1'b0;
    end else if (ctrlWr) begin
      cfgRun   <= wrData[B_RUN];
      cfgOutEn <= wrData[B_OE];
      cfgExtEn <= wrData[B_EXEN];
      cfgFast  <= wrData[B_FAST];
    end
  end

  // divide-by-two prescaler phase
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) divPhase <= 1'b0;
    else       divPhase <= ~divPhase;
  end

  // trigger pin synchronizer, idle high
  for (genvar g = 0; g < SYNC_STAGES; g++) begin : gSync
    if (g == 0) begin : gFirst
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) syncQ[g] <= 1'b1;
        else       syncQ[g] <= extPin;
      end
    end else begin : gNext
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) syncQ[g] <= 1'b1;
        else       syncQ[g] <= syncQ[g-1];
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) extPrev <= 1'b1;
    else       extPrev <= syncQ[LAST];
  end

  assign extFall = extPrev && !syncQ[LAST];

  // sticky event flag: a new edge wins over a clearing write
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                      extFlag <= 1'b0;
    else if (cfgExtEn && extFall)   extFlag <= 1'b1;
    else if (flagClr)               extFlag <= 1'b0;
  end

  // strobes toward the datapath
  always_comb begin
    strb        = '0;
    strb.tick   = cfgFast | divPhase;
    strb.run    = cfgRun;
    strb.wrByte = wrData;
    for (int unsigned i = 0; i < BYTES; i++) begin
      strb.wrCnt[i] = wrEn && (addr == cntAddr(i));
      strb.wrRld[i] = wrEn && (addr == rldAddr(i));
    end
  end

  // read mux
  always_comb begin
    rdData = '0;
    if (addr == A_CTRL) begin
      rdData[B_RUN]  = cfgRun;
      rdData[B_OE]   = cfgOutEn;
      rdData[B_EXEN] = cfgExtEn;
      rdData[B_FAST] = cfgFast;
      rdData[B_FLAG] = extFlag;
    end
    for (int unsigned i = 0; i < BYTES; i++) begin
      if (addr == cntAddr(i)) rdData = countVal[8*i +: 8];
      if (addr == rldAddr(i)) rdData = reloadVal[8*i +: 8];
    end
  end
endmodule

// File: rtl/sqt_dpath.sv
module sqt_dpath
  import sqt_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  dpStrb_t          strb,
  output logic [CNT_W-1:0] countVal,
  output logic [CNT_W-1:0] reloadVal,
  output logic             toggleQ
);
  logic anyCntWr, advance, wrapNow;

  assign anyCntWr = |strb.wrCnt;
  assign advance  = strb.tick && strb.run && !anyCntWr;
  assign wrapNow  = advance && (&countVal);

  // counter: byte writes take priority over counting
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      countVal <= '0;
    end else if (anyCntWr) begin
      for (int unsigned i = 0; i < BYTES; i++)
        if (strb.wrCnt[i]) countVal[8*i +: 8] <= strb.wrByte;
    end else if (wrapNow) begin
      countVal <= reloadVal;
    end else if (advance) begin
      countVal <= countVal + CNT_W'(1);
    end
  end

  // reload byte lanes
  for (genvar g = 0; g < BYTES; g++) begin : gRld
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)              reloadVal[8*g +: 8] <= '0;
      else if (strb.wrRld[g]) reloadVal[8*g +: 8] <= strb.wrByte;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)        toggleQ <= 1'b0;
    else if (wrapNow) toggleQ <= ~toggleQ;
  end
endmodule

// File: rtl/sqwave_timer.sv
module sqwave_timer
  import sqt_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wrData,
  output logic [7:0]        rdData,
  input  logic              extPin,
  output logic              clkOut,
  output logic              irq
);
  dpStrb_t          strb;
  logic [CNT_W-1:0] countVal, reloadVal;
  logic             toggleQ, cfgOutEn, cfgExtEn, extFlag;

  sqt_ctrl #(.SYNC_STAGES(SYNC_STAGES)) u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .wrData(wrData),
    .extPin(extPin), .countVal(countVal), .reloadVal(reloadVal),
    .strb(strb), .rdData(rdData), .cfgOutEn(cfgOutEn),
    .cfgExtEn(cfgExtEn), .extFlag(extFlag)
  );

  sqt_dpath u_dpath (
    .clk(clk), .rstN(rstN), .strb(strb),
    .countVal(countVal), .reloadVal(reloadVal), .toggleQ(toggleQ)
  );

  assign clkOut = cfgOutEn & toggleQ;
  assign irq    = extFlag;
endmodule

// File: rtl/sqt_checker.sv
module sqt_checker
  import sqt_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic              wrEn,
  input logic [ADDR_W-1:0] addr,
  input logic [7:0]        wrData,
  input dpStrb_t           strb,
  input logic [CNT_W-1:0]  countVal,
  input logic [CNT_W-1:0]  reloadVal,
  input logic              toggleQ,
  input logic              outEn,
  input logic              extEn,
  input logic              clkOut,
  input logic              irq
);
  logic noWr, clrWr;
  assign noWr  = !(|strb.wrCnt);
  assign clrWr = wrEn && (addr == A_CTRL) && !wrData[B_FLAG];

  p_stall_r3: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.run && noWr) |=> $stable(countVal));

  p_step_r4: assert property (@(posedge clk) disable iff (!rstN)
    (strb.tick && strb.run && noWr && !(&countVal)) |=> (countVal == $past(countVal) + CNT_W'(1)));

  p_wrap_r5: assert property (@(posedge clk) disable iff (!rstN)
    (strb.tick && strb.run && noWr && (&countVal)) |=> (countVal == $past(reloadVal)) && (toggleQ != $past(toggleQ)));

  p_hold_r5: assert property (@(posedge clk) disable iff (!rstN)
    !(strb.tick && strb.run && noWr && (&countVal)) |=> $stable(toggleQ));

  p_gate_r6: assert property (@(posedge clk) disable iff (!rstN)
    !outEn |-> !clkOut);

  p_wrprio_r7: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && addr == cntAddr(0)) |=> (countVal[7:0] == $past(wrData)));

  p_noext_r8: assert property (@(posedge clk) disable iff (!rstN)
    (!extEn && !irq) |=> !irq);

  p_keep_r9: assert property (@(posedge clk) disable iff (!rstN)
    (irq && !clrWr) |=> irq);

  p_clear_r9: assert property (@(posedge clk) disable iff (!rstN)
    (clrWr && !extEn) |=> !irq);
endmodule

bind sqwave_timer sqt_checker u_chk (
  .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .wrData(wrData),
  .strb(strb), .countVal(countVal), .reloadVal(reloadVal), .toggleQ(toggleQ),
  .outEn(cfgOutEn), .extEn(cfgExtEn), .clkOut(clkOut), .irq(irq)
);

// File: tb/sqwave_timer_tb.sv
module sqwave_timer_tb;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       wrEn = 1'b0;
  logic [2:0] addr = '0;
  logic [7:0] wrData = '0;
  logic       extPin = 1'b1;
  logic [7:0] rdData;
  logic       clkOut, irq;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sqwave_timer u_dut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .wrData(wrData),
    .rdData(rdData), .extPin(extPin), .clkOut(clkOut), .irq(irq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    wrEn = 1'b1; addr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    addr = a;
    #1;
    d = rdData;
  endtask

  task automatic rd16(output logic [15:0] v);
    logic [7:0] lo, hi;
    rd(3'd1, lo);
    rd(3'd2, hi);
    v = {hi, lo};
  endtask

  // clocks until clkOut next changes
  task automatic measure(output int n);
    logic last;
    last = clkOut;
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (clkOut == last && n < 5000);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0]  b;
    logic [15:0] v;
    int          n;
    bit          bad;

    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1 reset state
    for (int a = 0; a < 5; a++) begin
      rd(3'(a), b);
      check("R1 reg", {24'd0, b}, 32'd0);
    end
    check("R1 clkOut", {31'd0, clkOut}, 32'd0);
    check("R1 irq", {31'd0, irq}, 32'd0);

    // R2 map and readback
    wr(3'd3, 8'hA5); wr(3'd4, 8'h5A);
    rd(3'd3, b); check("R2 reload lo", {24'd0, b}, 32'hA5);
    rd(3'd4, b); check("R2 reload hi", {24'd0, b}, 32'h5A);
    wr(3'd0, 8'hFE);
    rd(3'd0, b); check("R2 ctrl", {24'd0, b}, 32'h0E);
    rd(3'd5, b); check("R2 unmapped", {24'd0, b}, 32'h00);
    wr(3'd0, 8'h00);

    // R3 stalled count
    wr(3'd1, 8'h34); wr(3'd2, 8'h12);
    repeat (10) @(negedge clk);
    rd16(v); check("R3 hold", {16'd0, v}, 32'h1234);

    // R4 fast rate
    wr(3'd1, 8'h00); wr(3'd2, 8'h01);
    wr(3'd0, 8'h09);
    repeat (20) @(negedge clk);
    rd16(v); check("R4 fast", {16'd0, v}, 32'h0114);
    wr(3'd0, 8'h00);

    // R4 normal rate
    wr(3'd1, 8'h00); wr(3'd2, 8'h01);
    wr(3'd0, 8'h01);
    repeat (20) @(negedge clk);
    rd16(v); check("R4 normal", {16'd0, v}, 32'h010A);
    wr(3'd0, 8'h00);

    // R7 write beats increment
    wr(3'd1, 8'h00); wr(3'd2, 8'h10);
    wr(3'd0, 8'h09);
    repeat (5) @(negedge clk);
    wr(3'd1, 8'h80);
    rd(3'd1, b); check("R7 lo written", {24'd0, b}, 32'h80);
    rd(3'd2, b); check("R7 hi kept", {24'd0, b}, 32'h10);
    repeat (3) @(negedge clk);
    rd(3'd1, b); check("R7 resumes", {24'd0, b}, 32'h83);
    wr(3'd0, 8'h00);

    // R6 output gating
    wr(3'd3, 8'hFF); wr(3'd4, 8'hFF); wr(3'd1, 8'hFF); wr(3'd2, 8'hFF);
    wr(3'd0, 8'h09);
    bad = 1'b0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (clkOut !== 1'b0) bad = 1'b1;
    end
    check("R6 gated low", {31'd0, bad}, 32'd0);
    wr(3'd0, 8'h0B);
    b[0] = clkOut;
    @(negedge clk);
    check("R6 toggles when enabled", {31'd0, clkOut}, {31'd0, ~b[0]});
    wr(3'd0, 8'h00);

    // R5 period sweep
    for (int f = 1; f >= 0; f--) begin
      for (int k = 0; k < 6; k++) begin
        int d;
        int r;
        logic [7:0] cfg;
        d = (k < 5) ? k + 1 : 300;
        r = 65536 - d;
        cfg = (f != 0) ? 8'h0A : 8'h02;
        wr(3'd0, cfg);
        wr(3'd3, r[7:0]); wr(3'd4, r[15:8]);
        wr(3'd1, 8'hFF); wr(3'd2, 8'hFF);
        wr(3'd0, cfg | 8'h01);
        measure(n);
        measure(n);
        check("R5 half-period", n, d * ((f != 0) ? 1 : 2));
        measure(n);
        check("R5 half-period repeat", n, d * ((f != 0) ? 1 : 2));
      end
    end
    wr(3'd0, 8'h00);

    // R8 / R9 event flag
    wr(3'd0, 8'h84);
    check("R9 write of 1 does not set", {31'd0, irq}, 32'd0);
    extPin = 1'b0;
    repeat (4) @(negedge clk);
    check("R8 falling edge sets", {31'd0, irq}, 32'd1);
    rd(3'd0, b); check("R9 flag readback", {24'd0, b & 8'h80}, 32'h80);
    wr(3'd0, 8'h84);
    repeat (3) @(negedge clk);
    check("R9 write of 1 keeps", {31'd0, irq}, 32'd1);
    wr(3'd0, 8'h04);
    check("R9 clear", {31'd0, irq}, 32'd0);
    extPin = 1'b1;
    repeat (5) @(negedge clk);
    check("R8 rising ignored", {31'd0, irq}, 32'd0);
    wr(3'd0, 8'h00);
    extPin = 1'b0;
    repeat (5) @(negedge clk);
    check("R8 disabled ignored", {31'd0, irq}, 32'd0);
    extPin = 1'b1;
    repeat (4) @(negedge clk);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule